// File: doc/BRIEF.md
# Drive Ready Qualifier and ATA Reset Sequencer

This block decides when the ATA side of a storage bridge may operate. It watches a "drive ready" signal from the attached drive, corrects its polarity with a configuration bit, and accepts a rising ready only after it has stayed asserted through a long filter interval. Once ready is accepted, the block waits a second interval, pulses the active-low ATA hardware reset, and then issues a one-cycle strobe that starts drive re-initialisation. A falling ready is honoured at once, in any state.

While the sequence has not reached the running state, the block holds the ATA protocol machines idle and forces the ATA output bus to zero. When the ATA enable is low, the bus is released, which is modelled as an output enable of 0. All intervals are given in microseconds and are converted to clock cycles from a clock-frequency parameter. The defaults are a 25 ms filter, a 25 ms delay and a 25 us reset pulse.

The states are S_NOTRDY, S_FILTER, S_DELAY, S_RSTPULSE and S_RUN. The transitions are:
- S_NOTRDY to S_FILTER when both the synchronised and the raw effective ready are high.
- S_FILTER to S_DELAY when the filter count expires.
- S_DELAY to S_RSTPULSE when the delay count expires.
- S_RSTPULSE to S_RUN when the pulse count expires.
- Any state to S_NOTRDY when the raw effective ready is low.

Top module: `ata_ready_seq`

## Requirements
- R1: The effective ready level is `dev_ready_raw` XOR `ready_invert`, so with `ready_invert`=1 a low input means ready.
- R2: A rising effective ready passes a two-flop synchroniser. S_FILTER is entered on the third rising clock edge after the input changes. The block then stays in S_FILTER for FILTER_CYC cycles.
- R3: When the effective ready is low at a rising edge, the block is in S_NOTRDY after that edge, whatever its state before. This path uses the raw input and does not wait for the synchroniser.
- R4: After S_FILTER, the block spends DELAY_CYC cycles in S_DELAY. Then `ata_reset_n` is 0 for exactly RESET_CYC cycles. With a stable ready input, `ata_reset_n` first reads 0 after rising edge 3+FILTER_CYC+DELAY_CYC, counted from the input change.
- R5: `ata_run` rises after edge 3+FILTER_CYC+DELAY_CYC+RESET_CYC. `init_start` is 1 in that first S_RUN cycle only.
- R6: A loss of ready at any edge up to and including the edge that would enter S_RUN aborts the sequence. In that case `init_start` and `ata_run` never assert, and `ata_reset_n` is 1 after the aborting edge.
- R7: Outside S_RUN, `ata_hold` is 1 and `ata_out` is all zeros. In S_RUN with `ata_enable`=1, `ata_out` equals `core_out` and `ata_hold` is 0.
- R8: `ata_oe` follows `ata_enable`; with `ata_enable`=0 the bus is released whatever the state.
- R9: After reset, the state is S_NOTRDY with `ata_run`=0, `init_start`=0, `ata_reset_n`=1 and `ata_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_ready_raw | input | 1 | Ready signal from the drive, asynchronous |
| ready_invert | input | 1 | Polarity configuration bit |
| ata_enable | input | 1 | ATA interface enable |
| core_out | input | ATA_W | Output bus from the ATA protocol machines |
| ata_out | output | ATA_W | Gated ATA output bus |
| ata_oe | output | 1 | Output enable of the ATA bus |
| ata_reset_n | output | 1 | Active-low ATA hardware reset |
| init_start | output | 1 | One-cycle strobe that starts drive initialisation |
| ata_run | output | 1 | Sequencer is in S_RUN |
| ata_hold | output | 1 | Holds the ATA protocol machines idle |

## Verification
The two functions that can fall in the same cycle are expiry of an interval counter and the immediate drop on loss of ready. The sharpest case is the last cycle of the reset pulse, where `init_start` would otherwise fire. The bench raises ready and then withdraws it after every possible number of edges, up to and including the edge that would enter S_RUN, for both polarities. For each abort it checks that neither `init_start` nor `ata_run` was ever seen, that the reset line is released, and that a later full sequence restarts with the complete arithmetic latency.

// File: rtl/ars_pkg.sv
package ars_pkg;
    typedef enum logic [2:0] {
        S_NOTRDY   = 3'd0,
        S_FILTER   = 3'd1,
        S_DELAY    = 3'd2,
        S_RSTPULSE = 3'd3,
        S_RUN      = 3'd4
    } ars_state_e;
endpackage

// File: rtl/ars_sync.sv
module ars_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ars_timer.sv
module ars_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CNT_W'(1));

    // R2
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R4
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/ata_ready_seq.sv
module ata_ready_seq
    import ars_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int FILTER_US = 25_000,
    parameter int DELAY_US  = 25_000,
    parameter int RESET_US  = 25,
    parameter int ATA_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_ready_raw,
    input  logic             ready_invert,
    input  logic             ata_enable,
    input  logic [ATA_W-1:0] core_out,
    output logic [ATA_W-1:0] ata_out,
    output logic             ata_oe,
    output logic             ata_reset_n,
    output logic             init_start,
    output logic             ata_run,
    output logic             ata_hold
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int FILTER_CYC = CYC_PER_US * FILTER_US;
    localparam int DELAY_CYC  = CYC_PER_US * DELAY_US;
    localparam int RESET_CYC  = CYC_PER_US * RESET_US;
    localparam int MAX_FD     = (FILTER_CYC > DELAY_CYC) ? FILTER_CYC : DELAY_CYC;
    localparam int MAX_CYC    = (MAX_FD > RESET_CYC) ? MAX_FD : RESET_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    ars_state_e       state, state_nx;
    logic             eff_raw, eff_sync;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             run_q, rst_n_q, init_q;

    assign eff_raw = dev_ready_raw ^ ready_invert;

    ars_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (eff_raw),
        .q     (eff_sync)
    );

    ars_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!eff_raw) begin
            state_nx = S_NOTRDY;
        end else begin
            unique case (state)
                S_NOTRDY:   if (eff_sync) state_nx = S_FILTER;
                S_FILTER:   if (tmr_done) state_nx = S_DELAY;
                S_DELAY:    if (tmr_done) state_nx = S_RSTPULSE;
                S_RSTPULSE: if (tmr_done) state_nx = S_RUN;
                S_RUN:      state_nx = S_RUN;
                default:    state_nx = S_NOTRDY;
            endcase
        end
    end

    // interval counter load on entry to a timed state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_nx != state) begin
            unique case (state_nx)
                S_FILTER:   begin tmr_load = 1'b1; tmr_val = CNT_W'(FILTER_CYC); end
                S_DELAY:    begin tmr_load = 1'b1; tmr_val = CNT_W'(DELAY_CYC);  end
                S_RSTPULSE: begin tmr_load = 1'b1; tmr_val = CNT_W'(RESET_CYC);  end
                default:    begin tmr_load = 1'b0; tmr_val = '0; end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_NOTRDY;
        else        state <= state_nx;
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rst_n_q <= 1'b1;
            init_q  <= 1'b0;
        end else begin
            run_q   <= (state_nx == S_RUN);
            rst_n_q <= (state_nx != S_RSTPULSE);
            init_q  <= (state == S_RSTPULSE) && (state_nx == S_RUN);
        end
    end

    assign ata_run     = run_q;
    assign ata_reset_n = rst_n_q;
    assign init_start  = init_q;
    assign ata_hold    = !run_q;
    assign ata_oe      = ata_enable;
    assign ata_out     = (run_q && ata_enable) ? core_out : '0;

    // R3
    drop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_raw |=> (state == S_NOTRDY && !ata_run));
    // R2
    filter_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILTER) |=> (state == S_FILTER || state == S_DELAY || state == S_NOTRDY));
    // R4
    reset_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ata_reset_n) |-> $past(state == S_DELAY));
    // R5
    init_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_run) |-> init_start);
    // R5
    init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start);
    // R7
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ata_hold |-> ata_out == '0);
endmodule

// File: tb/ata_ready_seq_bench.sv
module ata_ready_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FCYC = 6;
    localparam int DCYC = 4;
    localparam int PCYC = 3;
    localparam int W    = 8;
    localparam int TOTAL = 3 + FCYC + DCYC + PCYC;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dev_ready_raw = 1'b0;
    logic         ready_invert = 1'b0;
    logic         ata_enable = 1'b1;
    logic [W-1:0] core_out = '0;
    logic [W-1:0] ata_out;
    logic         ata_oe, ata_reset_n, init_start, ata_run, ata_hold;

    int checks = 0;
    int errors = 0;
    int init_seen = 0;
    int run_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_ready_seq #(
        .CLK_HZ(1_000_000), .FILTER_US(FCYC), .DELAY_US(DCYC),
        .RESET_US(PCYC), .ATA_W(W)
    ) u_ata_ready_seq (
        .clk(clk), .rst_n(rst_n), .dev_ready_raw(dev_ready_raw),
        .ready_invert(ready_invert), .ata_enable(ata_enable),
        .core_out(core_out), .ata_out(ata_out), .ata_oe(ata_oe),
        .ata_reset_n(ata_reset_n), .init_start(init_start),
        .ata_run(ata_run), .ata_hold(ata_hold)
    );

    always @(negedge clk) begin
        if (init_start) init_seen++;
        if (ata_run)    run_seen++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_eff(bit v);
        dev_ready_raw = v ^ ready_invert;
    endtask

    task automatic idle_low(int n);
        @(negedge clk); set_eff(1'b0);
        repeat (n) @(negedge clk);
    endtask

    // full sequence from a fresh rise; measures edge counts
    task automatic full_seq(string tag);
        int edges = 0, rst_first = -1, rst_len = 0, inits = 0;
        @(negedge clk); set_eff(1'b1);
        while (edges < 100) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (!ata_reset_n) begin
                if (rst_first < 0) rst_first = edges;
                rst_len++;
            end
            if (init_start) inits++;
            if (ata_run) break;
        end
        check({tag, " R5 run latency"}, edges, TOTAL);
        check({tag, " R4 reset start"}, rst_first, 3 + FCYC + DCYC);
        check({tag, " R4 reset length"}, rst_len, PCYC);
        check({tag, " R5 init in first run cycle"}, inits, 1);
        check({tag, " R7 hold released"}, ata_hold, 0);
        @(negedge clk);
        check({tag, " R5 init single cycle"}, init_start, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 run", ata_run, 0);
        check("R9 init", init_start, 0);
        check("R9 reset_n", ata_reset_n, 1);
        check("R9 hold", ata_hold, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int inv = 0; inv < 2; inv++) begin
            ready_invert = inv[0];
            idle_low(5);
            // R1 idle with polarity corrected: raw level opposite of ready
            check("R1 not ready at idle", ata_run, 0);
            full_seq(inv ? "R1 inverted" : "R1 direct");

            // R7 exhaustive output gating in run, R8 enable
            for (int p = 0; p < (1 << W); p++) begin
                core_out = W'(p);
                ata_enable = 1'b1;
                #1;
                check("R7 pass-through", ata_out, p);
                ata_enable = 1'b0;
                #1;
                check("R8 released", ata_oe, 0);
            end
            ata_enable = 1'b1;
            core_out = 8'hA5;

            // R3 immediate drop from run
            @(negedge clk); set_eff(1'b0);
            @(negedge clk);
            check("R3 run dropped", ata_run, 0);
            check("R7 hold after drop", ata_hold, 1);
            check("R7 bus zero after drop", ata_out, 0);
            check("R8 oe while not ready", ata_oe, 1);
            repeat (4) @(negedge clk);

            // R6 abort sweep, including the edge that would enter run
            for (int k = 0; k <= TOTAL - 1; k++) begin
                int i0, r0;
                idle_low(4);
                i0 = init_seen; r0 = run_seen;
                @(negedge clk); set_eff(1'b1);
                repeat (k) @(negedge clk);
                set_eff(1'b0);
                @(negedge clk);
                check("R6 reset released after abort", ata_reset_n, 1);
                repeat (3) @(negedge clk);
                check("R6 no init on abort", init_seen - i0, 0);
                check("R6 no run on abort", run_seen - r0, 0);
                check("R7 bus zero when aborted", ata_out, 0);
            end
            idle_low(4);
            // R2 and R3: after aborts the sequence restarts in full
            full_seq("R2 restart");
            idle_low(4);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule